// File: doc/BRIEF.md
# Head Recalibrate Step Sequencer

This block runs the recalibrate control command of a floppy disk controller. A one-cycle start request names a drive. The block zeroes that drive's present-cylinder counter. It then drives the direction line to the outward value and emits step pulses until the synchronised track-0 input shows that the head has arrived. Pulses are spaced by a programmable step-rate value. If the head has not arrived after a fixed number of pulses, the command ends with an abnormal-termination status.

The command returns no result bytes itself. On completion it latches a status-register-0 byte and raises an interrupt. The host collects the outcome with a sense-interrupt request. That request streams status register 0 and then the cylinder number, and clears the interrupt. A sense request made with no interrupt pending gets a single invalid-command byte. A new recalibrate issued before the sense discards the earlier outcome. The seek engine that lives next to this block updates the cylinder counters through a simple write port.

Top module: `head_home_seq`

## Requirements
- R1: After reset, step_out=0, dir_out=1, busy=0, irq=0 and sense_valid=0.
- R2: A cmd_start while idle sets busy=1 and dir_out=0 at the next clock edge and clears the cylinder counter of cmd_drive to 0. A later sense returns that 0 as its second byte.
- R3: Each step pulse is high for exactly 4 clock cycles. The low time between two consecutive pulses of one command is exactly max(step_rate,1)*16+2 cycles.
- R4: Stepping continues while the track-0 input, after two synchronising flip-flops, is 0. The number of pulses equals the number the head needs to reach track 0, which is zero when track-0 is already 1 at the start.
- R5: On reaching track 0 the command ends: busy=0, dir_out=1, irq=1. Status register 0 = 0x20 | drive, with IC in bits 7:6 = 00, seek-end in bit 5 = 1, equipment-check in bit 4 = 0, and the drive in bits 1:0.
- R6: If track 0 is not seen after 79 pulses, the command ends after exactly 79 pulses with IC=01 and seek-end=1, equipment-check=1. Status register 0 = 0x70 | drive.
- R7: A sense_req with irq pending and the block idle gives sense_valid on the next two cycles. The first byte is status register 0 with sense_last=0; the second is the drive's cylinder number with sense_last=1. irq is 0 from the first byte on.
- R8: A sense_req with no interrupt pending, or while busy, gives one cycle with sense_valid=1, sense_byte=0x80 and sense_last=1.
- R9: A cmd_start while busy is ignored: the running command and its drive number are unaffected.
- R10: A cmd_start while irq is pending clears irq at the next edge, and the earlier status is lost.
- R11: dir_out stays 0 on every cycle while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle recalibrate request |
| cmd_drive | input | 2 | Drive selected by the request |
| step_rate | input | 8 | Step spacing in units of 16 cycles (0 acts as 1) |
| trk0_in | input | 1 | Asynchronous track-0 indication, 1 = head at track 0 |
| pcn_we | input | 1 | Cylinder counter write from the seek engine |
| pcn_wdrive | input | 2 | Drive of the counter write |
| pcn_wval | input | 8 | Value of the counter write |
| sense_req | input | 1 | One-cycle sense-interrupt request |
| step_out | output | 1 | Step pulse to the drive |
| dir_out | output | 1 | Direction line, 0 = outward |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Interrupt, completion status pending |
| sense_valid | output | 1 | Sense byte valid |
| sense_byte | output | 8 | Sense result byte |
| sense_last | output | 1 | Last byte of the sense result |

## Verification
Properties checked on every cycle cover several invariants. The direction line stays low while busy, and no step appears while idle. A pulse is exactly four cycles wide, and the step counter never passes its limit. An interrupt never coexists with busy. A first sense byte is always followed by a last one, and a lone sense byte is always the invalid code. The bench scenarios cover what needs a model of the drive. That means the pulse count against the head position, the exact spacing for each step rate, and the status and cylinder values a sense returns. They also cover the loss of status on a restart, a start ignored while busy, and the 79-pulse failure boundary.

// File: rtl/head_home_pkg.sv
package head_home_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_HIGH,
        TM_GAP
    } tmr_state_e;

    localparam logic [7:0] SENSE_INVALID = 8'h80;

    // Status register 0: IC in 7:6, seek end in 5, equipment check in 4, unit in 1:0
    function automatic logic [7:0] build_st0(input logic failed, input logic [1:0] unit);
        logic [7:0] s;
        s      = '0;
        s[7:6] = failed ? 2'b01 : 2'b00;
        s[5]   = 1'b1;
        s[4]   = failed;
        s[1:0] = unit;
        return s;
    endfunction

endpackage

// File: rtl/home_sync2.sv
module home_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic meta;
        logic stable;
    } sync_reg_t;

    sync_reg_t sy_q, sy_d;

    always_comb begin
        sy_d.meta   = async_in;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_out = sy_q.stable;

endmodule

// File: rtl/home_step_timer.sv
module home_step_timer
    import head_home_pkg::*;
#(
    parameter int unsigned RATE_W    = 8,
    parameter int unsigned RATE_UNIT = 16,
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [RATE_W-1:0] rate,
    output logic              step,
    output logic              done
);

    localparam int unsigned CNT_W = RATE_W + $clog2(RATE_UNIT) + 1;
    localparam int unsigned PW_W  = $clog2(PULSE_CYC + 1) + 1;

    typedef struct packed {
        tmr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_reg_t;

    tmr_reg_t tm_q, tm_d;

    logic [CNT_W-1:0] eff_rate;
    logic [CNT_W-1:0] gap_len;

    always_comb begin
        eff_rate = (rate == '0) ? CNT_W'(1) : CNT_W'(rate);
        gap_len  = eff_rate * CNT_W'(RATE_UNIT);
    end

    always_comb begin
        tm_d      = tm_q;
        tm_d.done = 1'b0;
        unique case (tm_q.st)
            TM_IDLE: begin
                if (go) begin
                    tm_d.st  = TM_HIGH;
                    tm_d.cnt = CNT_W'(PULSE_CYC - 1);
                end
            end
            TM_HIGH: begin
                if (tm_q.cnt == '0) begin
                    tm_d.st  = TM_GAP;
                    tm_d.cnt = gap_len - CNT_W'(1);
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            TM_GAP: begin
                if (tm_q.cnt == '0) begin
                    tm_d.st   = TM_IDLE;
                    tm_d.done = 1'b1;
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            default: tm_d.st = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{st: TM_IDLE, cnt: '0, done: 1'b0};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign step = (tm_q.st == TM_HIGH);
    assign done = tm_q.done;

    // checker state: length of the current high phase
    logic [PW_W-1:0] hi_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q <= '0;
        end else if (step) begin
            hi_len_q <= hi_len_q + PW_W'(1);
        end else begin
            hi_len_q <= '0;
        end
    end

    AST_STEP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step) |-> hi_len_q == PW_W'(PULSE_CYC)); // R3
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (tm_q.st == TM_IDLE)); // R3
    AST_DONE_NOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !step); // R3

endmodule

// File: rtl/home_status.sv
module home_status
    import head_home_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned DRV_W      = 2,
    parameter int unsigned CYL_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DRV_W-1:0] start_drv,
    input  logic             fin,
    input  logic             fin_fail,
    input  logic [DRV_W-1:0] fin_drv,
    input  logic             busy,
    input  logic             pcn_we,
    input  logic [DRV_W-1:0] pcn_wdrv,
    input  logic [CYL_W-1:0] pcn_wval,
    input  logic             sense_req,
    output logic             irq,
    output logic             sense_valid,
    output logic [7:0]       sense_byte,
    output logic             sense_last
);

    typedef struct packed {
        logic [NUM_DRIVES-1:0][CYL_W-1:0] pcn;
        logic                             irq;
        logic [7:0]                       st0;
        logic [DRV_W-1:0]                 sdrv;
        logic                             second;
        logic                             valid;
        logic [7:0]                       byte_o;
        logic                             last;
    } stat_reg_t;

    stat_reg_t ss_q, ss_d;

    always_comb begin
        ss_d       = ss_q;
        ss_d.valid = 1'b0;
        ss_d.last  = 1'b0;

        if (pcn_we) begin
            ss_d.pcn[pcn_wdrv] = pcn_wval;
        end
        if (start) begin
            ss_d.pcn[start_drv] = '0;
            ss_d.irq            = 1'b0;
        end
        if (fin) begin
            ss_d.irq  = 1'b1;
            ss_d.st0  = build_st0(fin_fail, 2'(fin_drv));
            ss_d.sdrv = fin_drv;
        end

        if (ss_q.second) begin
            ss_d.valid  = 1'b1;
            ss_d.byte_o = 8'(ss_q.pcn[ss_q.sdrv]);
            ss_d.last   = 1'b1;
            ss_d.second = 1'b0;
        end else if (sense_req) begin
            ss_d.valid = 1'b1;
            if (ss_q.irq && !busy && !start) begin
                ss_d.byte_o = ss_q.st0;
                ss_d.second = 1'b1;
                ss_d.irq    = 1'b0;
            end else begin
                ss_d.byte_o = SENSE_INVALID;
                ss_d.last   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q <= '0;
        end else begin
            ss_q <= ss_d;
        end
    end

    assign irq         = ss_q.irq;
    assign sense_valid = ss_q.valid;
    assign sense_byte  = ss_q.byte_o;
    assign sense_last  = ss_q.last;

    AST_SENSE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_valid && !sense_last) |=> (sense_valid && sense_last)); // R7
    AST_SENSE_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_valid && !sense_last) |-> !irq); // R7
    AST_LONE_BYTE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_valid && sense_last && !$past(sense_valid && !sense_last))
            |-> sense_byte == SENSE_INVALID); // R8
    AST_START_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !fin) |=> !irq); // R10

endmodule

// File: rtl/head_home_seq.sv
module head_home_seq
    import head_home_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned RATE_W     = 8,
    parameter int unsigned RATE_UNIT  = 16,
    parameter int unsigned PULSE_CYC  = 4,
    parameter int unsigned MAX_STEPS  = 79,
    parameter int unsigned CYL_W      = 8,
    localparam int unsigned DRV_W     = $clog2(NUM_DRIVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [DRV_W-1:0]  cmd_drive,
    input  logic [RATE_W-1:0] step_rate,
    input  logic              trk0_in,
    input  logic              pcn_we,
    input  logic [DRV_W-1:0]  pcn_wdrive,
    input  logic [CYL_W-1:0]  pcn_wval,
    input  logic              sense_req,
    output logic              step_out,
    output logic              dir_out,
    output logic              busy,
    output logic              irq,
    output logic              sense_valid,
    output logic [7:0]        sense_byte,
    output logic              sense_last
);

    localparam int unsigned SC_W = $clog2(MAX_STEPS + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [DRV_W-1:0] drv;
        logic [SC_W-1:0]  cnt;
        logic             dir;
    } seq_reg_t;

    seq_reg_t sq_q, sq_d;

    logic trk0_s;
    logic tmr_go;
    logic tmr_done;
    logic start_ok;
    logic fin;
    logic fin_fail;

    home_sync2 #(.RST_VAL(1'b0)) u_trk0_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(trk0_in),
        .sync_out(trk0_s)
    );

    home_step_timer #(
        .RATE_W   (RATE_W),
        .RATE_UNIT(RATE_UNIT),
        .PULSE_CYC(PULSE_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (tmr_go),
        .rate (step_rate),
        .step (step_out),
        .done (tmr_done)
    );

    always_comb begin
        sq_d     = sq_q;
        tmr_go   = 1'b0;
        start_ok = 1'b0;
        fin      = 1'b0;
        fin_fail = 1'b0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (cmd_start) begin
                    start_ok = 1'b1;
                    sq_d.st  = SQ_CHECK;
                    sq_d.drv = cmd_drive;
                    sq_d.cnt = '0;
                    sq_d.dir = 1'b0;
                end
            end
            SQ_CHECK: begin
                if (trk0_s) begin
                    fin      = 1'b1;
                    sq_d.st  = SQ_IDLE;
                    sq_d.dir = 1'b1;
                end else if (sq_q.cnt == SC_W'(MAX_STEPS)) begin
                    fin      = 1'b1;
                    fin_fail = 1'b1;
                    sq_d.st  = SQ_IDLE;
                    sq_d.dir = 1'b1;
                end else begin
                    tmr_go   = 1'b1;
                    sq_d.cnt = sq_q.cnt + SC_W'(1);
                    sq_d.st  = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (tmr_done) begin
                    sq_d.st = SQ_CHECK;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, drv: '0, cnt: '0, dir: 1'b1};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy    = (sq_q.st != SQ_IDLE);
    assign dir_out = sq_q.dir;

    home_status #(
        .NUM_DRIVES(NUM_DRIVES),
        .DRV_W     (DRV_W),
        .CYL_W     (CYL_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_ok),
        .start_drv  (cmd_drive),
        .fin        (fin),
        .fin_fail   (fin_fail),
        .fin_drv    (sq_q.drv),
        .busy       (busy),
        .pcn_we     (pcn_we),
        .pcn_wdrv   (pcn_wdrive),
        .pcn_wval   (pcn_wval),
        .sense_req  (sense_req),
        .irq        (irq),
        .sense_valid(sense_valid),
        .sense_byte (sense_byte),
        .sense_last (sense_last)
    );

    AST_DIR_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dir_out); // R11
    AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !step_out); // R4
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.cnt <= SC_W'(MAX_STEPS)); // R6
    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start && !fin) |=> (busy && $stable(sq_q.drv))); // R9
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start) |=> (busy && !dir_out)); // R2

endmodule

// File: tb/head_home_seq_tb.sv
module head_home_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] cmd_drive = '0;
    logic [7:0] step_rate = '0;
    logic       trk0_in;
    logic       pcn_we = 1'b0;
    logic [1:0] pcn_wdrive = '0;
    logic [7:0] pcn_wval = '0;
    logic       sense_req = 1'b0;
    logic       step_out, dir_out, busy, irq, sense_valid, sense_last;
    logic [7:0] sense_byte;

    always #10 clk = ~clk;

    head_home_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_drive(cmd_drive),
        .step_rate(step_rate), .trk0_in(trk0_in), .pcn_we(pcn_we),
        .pcn_wdrive(pcn_wdrive), .pcn_wval(pcn_wval), .sense_req(sense_req),
        .step_out(step_out), .dir_out(dir_out), .busy(busy), .irq(irq),
        .sense_valid(sense_valid), .sense_byte(sense_byte), .sense_last(sense_last)
    );

    int n_chk = 0;
    int n_bad = 0;

    // drive model and pulse monitor
    int   target = 0;
    int   pulses = 0;
    int   hi_run = 0;
    int   lo_run = 0;
    int   exp_low = 18;
    int   width_bad = 0;
    int   gap_bad = 0;
    int   dir_bad = 0;
    logic prev_step = 1'b0;

    assign trk0_in = (pulses >= target);

    always @(negedge clk) begin
        if (step_out) begin
            if (!prev_step) begin
                if (pulses > 0 && lo_run != exp_low) gap_bad++;
                pulses++;
                hi_run = 1;
            end else begin
                hi_run++;
            end
        end else begin
            if (prev_step) begin
                if (hi_run != 4) width_bad++;
                lo_run = 1;
            end else begin
                lo_run++;
            end
        end
        if (busy && dir_out) dir_bad++;
        prev_step = step_out;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_st0(input int drv, input int tgt);
        return (tgt > 79) ? (32'h70 | drv) : (32'h20 | drv);
    endfunction

    function automatic int exp_pulses(input int tgt);
        return (tgt > 79) ? 79 : tgt;
    endfunction

    task automatic do_sense(output int v0, output int b0, output int l0,
                            output int v1, output int b1, output int l1);
        @(negedge clk); sense_req = 1'b1;
        @(negedge clk); sense_req = 1'b0;
        v0 = int'(sense_valid); b0 = int'(sense_byte); l0 = int'(sense_last);
        @(negedge clk);
        v1 = int'(sense_valid); b1 = int'(sense_byte); l1 = int'(sense_last);
    endtask

    task automatic wait_idle();
        int waited = 0;
        while (busy && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic arm(input int drv, input int rate, input int tgt);
        @(negedge clk);
        target    = tgt;
        pulses    = 0;
        width_bad = 0;
        gap_bad   = 0;
        dir_bad   = 0;
        exp_low   = ((rate == 0) ? 1 : rate) * 16 + 2;
        step_rate = 8'(rate);
        cmd_drive = 2'(drv);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_recal(input int drv, input int rate, input int tgt,
                             input int pre_pcn, input bit sense_after);
        int v0, b0, l0, v1, b1, l1;
        if (pre_pcn >= 0) begin
            @(negedge clk);
            pcn_we = 1'b1; pcn_wdrive = 2'(drv); pcn_wval = 8'(pre_pcn);
            @(negedge clk);
            pcn_we = 1'b0;
        end
        arm(drv, rate, tgt);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 dir after start", int'(dir_out), 0);
        wait_idle();
        check("R4 pulse count", pulses, exp_pulses(tgt));
        check("R3 pulse width errors", width_bad, 0);
        check("R3 pulse spacing errors", gap_bad, 0);
        check("R11 dir high while busy", dir_bad, 0);
        check("R5 irq at end", int'(irq), 1);
        check("R5 dir released", int'(dir_out), 1);
        if (sense_after) begin
            do_sense(v0, b0, l0, v1, b1, l1);
            check("R7 first byte valid", v0, 1);
            check((tgt > 79) ? "R6 status byte" : "R5 status byte", b0, exp_st0(drv, tgt));
            check("R7 first not last", l0, 0);
            check("R7 second byte valid/last", v1 + l1, 2);
            check("R2 cylinder cleared", b1, 0);
            check("R7 irq cleared", int'(irq), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v0, b0, l0, v1, b1, l1;
        int seed;
        seed = $urandom(32'd20240611);
        target = 0;
        repeat (3) @(negedge clk);
        check("R1 step at reset", int'(step_out), 0);
        check("R1 dir at reset", int'(dir_out), 1);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 irq at reset", int'(irq), 0);
        check("R1 sense_valid at reset", int'(sense_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: sense with nothing pending
        do_sense(v0, b0, l0, v1, b1, l1);
        check("R8 idle sense byte", b0, 32'h80);
        check("R8 idle sense valid/last", v0 + l0, 2);
        check("R8 no second byte", v1, 0);

        // directed corners
        run_recal(2, 1, 0, 32'h35, 1'b1);   // R4 already at track 0
        run_recal(1, 0, 79, 32'h4e, 1'b1);  // R4 reached on the last allowed pulse
        run_recal(3, 0, 80, -1, 1'b1);      // R6 never reached
        run_recal(0, 2, 5, 32'h11, 1'b1);

        // R9 and R8: start and sense while busy
        arm(1, 1, 6);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (10) @(negedge clk);
        cmd_drive = 2'd3;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R9 still busy", int'(busy), 1);
        do_sense(v0, b0, l0, v1, b1, l1);
        check("R8 busy sense byte", b0, 32'h80);
        check("R8 busy sense last", v0 + l0, 2);
        wait_idle();
        check("R9 pulse count unchanged", pulses, 6);
        do_sense(v0, b0, l0, v1, b1, l1);
        check("R9 status keeps first drive", b0, 32'h21);

        // R10: restart while irq pending loses the old status
        run_recal(0, 1, 2, -1, 1'b0);
        arm(2, 1, 0);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R10 irq dropped on restart", int'(irq), 0);
        wait_idle();
        do_sense(v0, b0, l0, v1, b1, l1);
        check("R10 status from new command", b0, 32'h22);
        do_sense(v0, b0, l0, v1, b1, l1);
        check("R8 second sense invalid", b0, 32'h80);
        check("R8 second sense last", l0, 1);

        // constrained random trials
        for (int t = 0; t < 10; t++) begin
            int drv, rate, tgt, pre;
            drv  = int'($urandom % 4);
            rate = int'($urandom % 4);
            tgt  = int'($urandom % 90);
            pre  = int'($urandom % 256);
            run_recal(drv, rate, tgt, pre, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule